// File: doc/BRIEF.md
# Region-Aware Way-Enable Generator for a Shared Last-Level Cache

This block decides which ways of a shared last-level cache are switched on for each lookup. It holds a small permission table with one entry per way. Each entry has one access bit per core, a bit that places the way in the shared region, and a drain bit that opens the way to every core while dirty lines are written back.

For each request the block takes the requesting core number and a class hint from the coherence directory, and drives a one-hot-per-way enable mask at once, with no register on the way. The hint is one of three values. Lines held exclusive or modified are private, lines held in shared state are shared, and an address with no directory entry is unknown. Private lookups touch only the core's own non-shared ways. Shared lookups touch only the shared region. Unknown lookups touch both.

A reconfiguration controller edits single bits of the table through a write port. The block also reports the ways that nobody can reach, so that they can be power-gated.

Top module: `llc_way_enable_gen`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), way 0 has every core bit set. Every other way has no core bit set. No way has its shared bit or its drain bit set.
- R2: With req_valid high and req_class = 2'b00 (private), way_en bit w is set when way w has the core bit of req_core set and its shared bit clear, or when its drain bit is set.
- R3: With req_valid high and req_class = 2'b01 (shared), way_en bit w is set exactly when way w has its shared bit or its drain bit set.
- R4: With req_valid high and req_class = 2'b10 (no directory entry), or the unused code 2'b11, way_en is the union of the private and the shared masks for req_core.
- R5: A way whose drain bit is set is enabled for every valid request, whatever the requesting core and class.
- R6: With req_valid low, way_en is all zeros.
- R7: A write (wr_en high at a clock edge) changes one bit of entry wr_way. The bit is chosen by wr_sel: 2'b00 is core bit wr_core, 2'b01 is the shared bit, 2'b10 is the drain bit. The bit takes the value wr_value. The change appears on the outputs only after that edge, not during the write cycle.
- R8: A write with wr_sel = 2'b11, or any cycle with wr_en low, leaves the whole table unchanged.
- R9: gate_mask bit w is set exactly when way w has no core bit, no shared bit and no drain bit set. It does not depend on the request inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_core | input | 3 | Requesting core number |
| req_class | input | 2 | Directory class: 00 private, 01 shared, 10 no entry |
| way_en | output | 8 | Ways to activate for this lookup |
| gate_mask | output | 8 | Ways that no core can reach |
| wr_en | input | 1 | Table write strobe |
| wr_way | input | 3 | Entry to modify |
| wr_sel | input | 2 | Bit to modify: 00 core bit, 01 shared, 10 drain, 11 none |
| wr_core | input | 3 | Core bit index when wr_sel is 00 |
| wr_value | input | 1 | Value written to the chosen bit |

## Verification
The enable mask is probed with the same core under all four class codes, and with different cores under the same class. This separates the per-core filter from the region filter. Ways that carry both a core bit and the shared bit show whether a private lookup wrongly reaches into the shared region. A drain bit set on a way that is otherwise empty shows that the override ignores both core and class, and that it removes the way from the gate mask. Each write is issued in the same cycle as a lookup, which shows whether the new bit leaks into that cycle. Reserved selector codes and idle write cycles are then followed by lookups that would expose any change.

// File: rtl/llc_wen_pkg.sv
// Package: shared encodings for the way-enable generator.
// Assumes: two-bit class and selector codes, fixed by the port definitions.
package llc_wen_pkg;

    typedef enum logic [1:0] {
        CLS_PRIVATE  = 2'b00,
        CLS_SHARED   = 2'b01,
        CLS_NOENTRY  = 2'b10,
        CLS_RESERVED = 2'b11
    } data_class_e;

    typedef enum logic [1:0] {
        SEL_CORE   = 2'b00,
        SEL_SHARED = 2'b01,
        SEL_DRAIN  = 2'b10,
        SEL_NONE   = 2'b11
    } perm_sel_e;

endpackage

// File: rtl/wen_perm_table.sv
// Module: per-way permission storage. One entry per way: a core bit per core,
// a shared-region bit and a drain bit.
// Assumes: a single write per cycle; the write lands at the clock edge.
module wen_perm_table
    import llc_wen_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int NUM_WAYS  = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [WAY_W-1:0]                   wr_way,
    input  logic [1:0]                         wr_sel,
    input  logic [CORE_W-1:0]                  wr_core,
    input  logic                               wr_value,
    output logic [NUM_WAYS-1:0][NUM_CORES-1:0] core_bits,
    output logic [NUM_WAYS-1:0]                shared_vec,
    output logic [NUM_WAYS-1:0]                drain_vec
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_entry
        localparam logic [WAY_W-1:0] WAY_IDX = WAY_W'(w);
        localparam logic [NUM_CORES-1:0] CORE_RST = (w == 0) ? '1 : '0;
        logic hit;

        // Purpose: decode whether this cycle's write targets this entry.
        assign hit = wr_en && (wr_way == WAY_IDX);

        // Purpose: hold the entry and apply a single-bit update on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                core_bits[w]  <= CORE_RST;
                shared_vec[w] <= 1'b0;
                drain_vec[w]  <= 1'b0;
            end else if (hit) begin
                case (perm_sel_e'(wr_sel))
                    SEL_CORE:   core_bits[w][wr_core] <= wr_value;
                    SEL_SHARED: shared_vec[w]         <= wr_value;
                    SEL_DRAIN:  drain_vec[w]          <= wr_value;
                    default:    ;
                endcase
            end
        end
    end

endmodule

// File: rtl/wen_region_select.sv
// Module: combinational way selection from the core number, the directory
// class and the permission table.
// Assumes: req_core is below NUM_CORES; class code 11 is treated as no entry.
module wen_region_select
    import llc_wen_pkg::*;
#(
    parameter int NUM_CORES = 8,
    parameter int NUM_WAYS  = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                               req_valid,
    input  logic [CORE_W-1:0]                  req_core,
    input  logic [1:0]                         req_class,
    input  logic [NUM_WAYS-1:0][NUM_CORES-1:0] core_bits,
    input  logic [NUM_WAYS-1:0]                shared_vec,
    input  logic [NUM_WAYS-1:0]                drain_vec,
    output logic [NUM_WAYS-1:0]                way_en
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic own;
        logic region_hit;

        // Purpose: the way is private to the requester when not in the shared region.
        assign own = core_bits[w][req_core] & ~shared_vec[w];

        // Purpose: pick the region(s) searched for this class of data.
        always_comb begin
            case (data_class_e'(req_class))
                CLS_PRIVATE: region_hit = own;
                CLS_SHARED:  region_hit = shared_vec[w];
                default:     region_hit = own | shared_vec[w];
            endcase
        end

        // Purpose: drain override opens the way to any valid request.
        assign way_en[w] = req_valid & (region_hit | drain_vec[w]);
    end

endmodule

// File: rtl/wen_gate_detect.sv
// Module: flags ways that no core, region or drain can reach.
// Assumes: the table outputs are registered, so the mask is glitch-free per cycle.
module wen_gate_detect #(
    parameter int NUM_CORES = 8,
    parameter int NUM_WAYS  = 8
) (
    input  logic [NUM_WAYS-1:0][NUM_CORES-1:0] core_bits,
    input  logic [NUM_WAYS-1:0]                shared_vec,
    input  logic [NUM_WAYS-1:0]                drain_vec,
    output logic [NUM_WAYS-1:0]                gate_mask
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        // Purpose: a way is idle when none of its entry bits is set.
        assign gate_mask[w] = ~((|core_bits[w]) | shared_vec[w] | drain_vec[w]);
    end

endmodule

// File: rtl/llc_way_enable_gen.sv
// Module: top of the way-enable generator. Joins the permission table, the
// region selector and the gate detector.
// Assumes: the request path is combinational; writes take effect after the edge.
module llc_way_enable_gen #(
    parameter int NUM_CORES = 8,
    parameter int NUM_WAYS  = 8,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [CORE_W-1:0]   req_core,
    input  logic [1:0]          req_class,
    output logic [NUM_WAYS-1:0] way_en,
    output logic [NUM_WAYS-1:0] gate_mask,
    input  logic                wr_en,
    input  logic [WAY_W-1:0]    wr_way,
    input  logic [1:0]          wr_sel,
    input  logic [CORE_W-1:0]   wr_core,
    input  logic                wr_value
);

    logic [NUM_WAYS-1:0][NUM_CORES-1:0] core_bits;
    logic [NUM_WAYS-1:0]                shared_vec;
    logic [NUM_WAYS-1:0]                drain_vec;

    wen_perm_table #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_way     (wr_way),
        .wr_sel     (wr_sel),
        .wr_core    (wr_core),
        .wr_value   (wr_value),
        .core_bits  (core_bits),
        .shared_vec (shared_vec),
        .drain_vec  (drain_vec)
    );

    wen_region_select #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_select (
        .req_valid  (req_valid),
        .req_core   (req_core),
        .req_class  (req_class),
        .core_bits  (core_bits),
        .shared_vec (shared_vec),
        .drain_vec  (drain_vec),
        .way_en     (way_en)
    );

    wen_gate_detect #(.NUM_CORES(NUM_CORES), .NUM_WAYS(NUM_WAYS)) u_gate (
        .core_bits  (core_bits),
        .shared_vec (shared_vec),
        .drain_vec  (drain_vec),
        .gate_mask  (gate_mask)
    );

endmodule

// File: rtl/llc_way_enable_gen_chk.sv
// Module: assertion checker bound to the way-enable generator.
// Assumes: it sees the table's shared and drain vectors through the bind.
module llc_way_enable_gen_chk #(
    parameter int NUM_WAYS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [1:0]          req_class,
    input logic                wr_en,
    input logic [1:0]          wr_sel,
    input logic [NUM_WAYS-1:0] way_en,
    input logic [NUM_WAYS-1:0] gate_mask,
    input logic [NUM_WAYS-1:0] shared_vec,
    input logic [NUM_WAYS-1:0] drain_vec
);

    a_r6_idle_no_ways: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (way_en == '0));

    a_r9_gated_never_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (way_en & gate_mask) == '0);

    a_r5_drain_always_open: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((drain_vec & ~way_en) == '0));

    a_r3_shared_only_region: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_class == 2'b01) |-> ((way_en & ~(shared_vec | drain_vec)) == '0));

    a_r8_idle_write_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(gate_mask));

    a_r8_reserved_sel_keeps_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'b11) |=> ($stable(gate_mask) && $stable(shared_vec) && $stable(drain_vec)));

endmodule

bind llc_way_enable_gen llc_way_enable_gen_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_class  (req_class),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .way_en     (way_en),
    .gate_mask  (gate_mask),
    .shared_vec (shared_vec),
    .drain_vec  (drain_vec)
);

// File: tb/llc_way_enable_gen_bench.sv
`timescale 1ns/1ps
module llc_way_enable_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_core = '0;
    logic [1:0] req_class = '0;
    logic [7:0] way_en;
    logic [7:0] gate_mask;
    logic       wr_en = 1'b0;
    logic [2:0] wr_way = '0;
    logic [1:0] wr_sel = '0;
    logic [2:0] wr_core = '0;
    logic       wr_value = 1'b0;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] q_en[$];
    logic [7:0] q_gate[$];
    string      q_tag[$];

    // Reference model of the table, built from the requirements.
    logic [7:0] m_core [8];
    logic [7:0] m_sh;
    logic [7:0] m_dr;

    always #10 clk = ~clk;

    llc_way_enable_gen u_llc_way_enable_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
        .req_class(req_class), .way_en(way_en), .gate_mask(gate_mask),
        .wr_en(wr_en), .wr_way(wr_way), .wr_sel(wr_sel), .wr_core(wr_core),
        .wr_value(wr_value)
    );

    function automatic logic [7:0] model_en(input bit v, input int c, input logic [1:0] k);
        logic [7:0] r;
        for (int w = 0; w < 8; w++) begin
            logic own;
            logic hit;
            own = m_core[w][c] & ~m_sh[w];
            case (k)
                2'b00:   hit = own;
                2'b01:   hit = m_sh[w];
                default: hit = own | m_sh[w];
            endcase
            r[w] = v & (hit | m_dr[w]);
        end
        return r;
    endfunction

    function automatic logic [7:0] model_gate();
        logic [7:0] r;
        for (int w = 0; w < 8; w++) r[w] = ~((|m_core[w]) | m_sh[w] | m_dr[w]);
        return r;
    endfunction

    // Driver: one cycle of stimulus; queues the outputs expected before any write lands.
    task automatic step(input bit v, input int c, input logic [1:0] k,
                        input bit we, input int way, input logic [1:0] sel,
                        input int wc, input bit val, input string tag);
        @(posedge clk);
        #3;
        req_valid = v; req_core = 3'(c); req_class = k;
        wr_en = we; wr_way = 3'(way); wr_sel = sel; wr_core = 3'(wc); wr_value = val;
        q_en.push_back(model_en(v, c, k));
        q_gate.push_back(model_gate());
        q_tag.push_back(tag);
        if (we) begin
            case (sel)
                2'b00:   m_core[way][wc] = val;
                2'b01:   m_sh[way] = val;
                2'b10:   m_dr[way] = val;
                default: ;
            endcase
        end
    endtask

    task automatic look(input int c, input logic [1:0] k, input string tag);
        step(1'b1, c, k, 1'b0, 0, 2'b00, 0, 1'b0, tag);
    endtask

    task automatic put(input int way, input logic [1:0] sel, input int wc, input bit val, input string tag);
        step(1'b1, 0, 2'b10, 1'b1, way, sel, wc, val, tag);
    endtask

    // Monitor: compares queued expectations mid-cycle, away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            if (q_en.size() > 0) begin
                logic [7:0] e_en;
                logic [7:0] e_g;
                string t;
                e_en = q_en.pop_front();
                e_g = q_gate.pop_front();
                t = q_tag.pop_front();
                n_vec++;
                if (way_en !== e_en || gate_mask !== e_g) begin
                    n_bad++;
                    $display("FAIL %s: way_en=%h gate_mask=%h expected way_en=%h gate_mask=%h",
                             t, way_en, gate_mask, e_en, e_g);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < 8; w++) m_core[w] = (w == 0) ? 8'hFF : 8'h00;
        m_sh = '0;
        m_dr = '0;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;

        // R1 reset contents, seen through private and shared lookups
        look(3, 2'b00, "R1 reset private core3");
        look(7, 2'b01, "R1 reset shared");
        // R6 idle request
        step(1'b0, 2, 2'b10, 1'b0, 0, 2'b00, 0, 1'b0, "R6 idle request");

        // R7 build a layout; each write cycle also checks the old view
        put(1, 2'b00, 2, 1'b1, "R7 write core2 way1 same cycle");
        look(2, 2'b00, "R7 core2 way1 next cycle");
        put(2, 2'b00, 2, 1'b1, "R7 write core2 way2");
        put(3, 2'b00, 5, 1'b1, "R7 write core5 way3");
        put(5, 2'b01, 0, 1'b1, "R7 write shared way5");
        put(6, 2'b01, 0, 1'b1, "R7 write shared way6");

        // R2 private lookups for several cores
        look(2, 2'b00, "R2 private core2");
        look(5, 2'b00, "R2 private core5");
        look(7, 2'b00, "R2 private core7");
        // R3 shared lookup
        look(4, 2'b01, "R3 shared core4");
        // R4 no entry and unused code
        look(2, 2'b10, "R4 noentry core2");
        look(5, 2'b11, "R4 code11 core5");

        // R2 a way with a core bit that also joins the shared region
        put(1, 2'b01, 0, 1'b1, "R7 write shared way1");
        look(2, 2'b00, "R2 private excludes shared way1");
        look(6, 2'b01, "R3 shared includes way1");

        // R5 drain on a populated way and on an empty way
        put(3, 2'b10, 0, 1'b1, "R7 write drain way3");
        put(7, 2'b10, 0, 1'b1, "R7 write drain way7");
        look(7, 2'b00, "R5 drain private core7");
        look(0, 2'b01, "R5 drain shared core0");
        look(4, 2'b10, "R5 drain noentry core4");

        // R7 clearing bits
        put(0, 2'b00, 7, 1'b0, "R7 clear core7 way0");
        look(7, 2'b00, "R7 core7 after clear");
        put(7, 2'b10, 0, 1'b0, "R7 clear drain way7");
        look(1, 2'b10, "R9 way7 gated again");

        // R8 reserved selector and idle write cycles
        step(1'b1, 4, 2'b10, 1'b1, 4, 2'b11, 4, 1'b1, "R8 reserved sel write");
        look(4, 2'b10, "R8 reserved sel no change");
        step(1'b1, 4, 2'b00, 1'b0, 4, 2'b00, 4, 1'b1, "R8 wr_en low");
        look(4, 2'b00, "R8 wr_en low no change");

        // R9 gate mask independent of request inputs
        step(1'b0, 0, 2'b01, 1'b0, 0, 2'b00, 0, 1'b0, "R9 gate with idle request");

        @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule